// File: doc/BRIEF.md
# Ternary Unary Gate Unit

This block runs three balanced-ternary data lanes, each through its own programmable single-input ternary gate. Every trit crosses the block boundary as a two-bit code. A gate is described by three trits, which together select one of the 27 possible mappings from one trit to one trit. The first lane's gate comes from a six-bit configuration word. The second lane's gate comes from another six-bit word. The third lane's gate is set by three directly supplied configuration trits, packed the same way.

The configuration is captured on a load strobe. Each data trit is sampled every clock, and its mapped result appears on the lane output one clock later. Every output also drives a one-hot red/green/blue indicator. Two active-low controls govern the block. Chip enable freezes all internal state while it is high. Output enable, together with chip enable, decides whether the outputs are driven or show the illegal code as a high-impedance marker. An illegal code on any input never becomes a value: the held value stays in place, and a one-cycle error flag reports the event.

Top module: `ternUnaryGateUnit`

## Requirements
- R1: Trit codes are 2'b00 for +, 2'b10 for 0 and 2'b01 for −, and 2'b11 is illegal. In a six-bit gate word, bits [1:0] give the output for input −, bits [3:2] the output for input 0, and bits [5:4] the output for input +.
- R2: A data trit sampled at a rising edge, while chip enable is low, appears as its mapped value on the lane output right after that edge. The output holds until the next sampling edge.
- R3: Gate words are captured only at an edge where cfgLoad is high and ceN is low. At any other edge, changes on the word ports have no effect on the mapping. A data trit sampled at the load edge is mapped with the previous configuration.
- R4: Lane A (dataA→zA) uses cfgWordA, lane B uses cfgWordB, and lane C uses cfgSwitch.
- R5: A 2'b11 trit inside a loaded word leaves that trit's previous setting unchanged, while the legal trits of the same word are loaded. The matching cfgErr bit is high for exactly the cycle after that load edge.
- R6: A 2'b11 data trit is mapped as the last legal trit held for that lane. The matching dataErr bit is high for the cycle after each such sample.
- R7: While outputs are valid, each indicator is one-hot {red,green,blue}: 3'b100 for +, 3'b010 for 0 and 3'b001 for −.
- R8: While ceN or oeN is high, every z output shows 2'b11, every indicator shows 3'b000 and outValid is low. This gating is combinational.
- R9: While ceN is high, no configuration or data is captured and both error vectors are zero. After re-enabling, the outputs show the held results.
- R10: Reset (rstN low) sets every gate to identity (− to −, 0 to 0, + to +), the held data and the lane results to 0, and clears the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low chip enable; high freezes state and masks outputs |
| oeN | input | 1 | Active-low output enable |
| cfgLoad | input | 1 | Capture strobe for the three gate words |
| cfgWordA | input | 6 | Gate word for lane A (three trit codes) |
| cfgWordB | input | 6 | Gate word for lane B |
| cfgSwitch | input | 6 | Directly supplied gate trits for lane C |
| dataA | input | 2 | Data trit, lane A |
| dataB | input | 2 | Data trit, lane B |
| dataC | input | 2 | Data trit, lane C |
| zA | output | 2 | Mapped trit, lane A (2'b11 when masked) |
| zB | output | 2 | Mapped trit, lane B |
| zC | output | 2 | Mapped trit, lane C |
| rgbA | output | 3 | One-hot {red,green,blue} indicator, lane A |
| rgbB | output | 3 | Indicator, lane B |
| rgbC | output | 3 | Indicator, lane C |
| outValid | output | 1 | Outputs are driven |
| cfgErr | output | 3 | Per-lane illegal configuration trit seen at last load (bit 0 = lane A) |
| dataErr | output | 3 | Per-lane illegal data trit seen at last sample (bit 0 = lane A) |

## Verification
The bench builds the block with its default parameters: three lanes, a two-bit trit code and three trits per gate word. At that size, all 27 data combinations can be swept through three lanes programmed with three different mappings (an inverter, a constant and a rotation). A load with a single illegal trit then shows partial updating of one gate word. The bench also covers a load attempted while the chip is disabled and a held data trit across an illegal sample.

// File: rtl/ternPkg.sv
package ternPkg;
  localparam int TRIT_W     = 2;
  localparam int GATE_TRITS = 3;
  localparam int CFG_W      = TRIT_W * GATE_TRITS;

  typedef logic [TRIT_W-1:0] tritCode_t;

  localparam tritCode_t TRIT_POS  = 2'b00;
  localparam tritCode_t TRIT_ZERO = 2'b10;
  localparam tritCode_t TRIT_NEG  = 2'b01;
  localparam tritCode_t TRIT_BAD  = 2'b11;

  // identity gate: slot0 (input -) -> -, slot1 (0) -> 0, slot2 (+) -> +
  localparam logic [CFG_W-1:0] CFG_IDENT = {TRIT_POS, TRIT_ZERO, TRIT_NEG};

  typedef struct packed {
    logic capCfg;
    logic capData;
    logic outEn;
  } ctrlStrobe_t;

  function automatic logic [2:0] tritToRgb(input tritCode_t t);
    case (t)
      TRIT_POS:  return 3'b100;
      TRIT_ZERO: return 3'b010;
      TRIT_NEG:  return 3'b001;
      default:   return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/ternCtrl.sv
module ternCtrl
  import ternPkg::*;
(
  input  logic        ceN,
  input  logic        oeN,
  input  logic        cfgLoad,
  output ctrlStrobe_t strobe
);
  logic chipOn;

  assign chipOn         = ~ceN;
  assign strobe.capCfg  = chipOn & cfgLoad;
  assign strobe.capData = chipOn;
  assign strobe.outEn   = chipOn & ~oeN;
endmodule

// File: rtl/ternLaneArray.sv
module ternLaneArray
  import ternPkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [LANES*CFG_W-1:0]  cfgIn,
  input  logic [LANES*TRIT_W-1:0] dataIn,
  output logic [LANES*TRIT_W-1:0] zOut,
  output logic [LANES*3-1:0]      rgbOut,
  output logic [LANES-1:0]        cfgErr,
  output logic [LANES-1:0]        dataErr
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [CFG_W-1:0] cfgQ;
    logic [CFG_W-1:0] cfgNew;
    logic [CFG_W-1:0] cfgNext;
    logic             cfgBad;
    tritCode_t        dIn;
    tritCode_t        dEff;
    tritCode_t        heldQ;
    tritCode_t        zQ;
    tritCode_t        gateOut;
    logic             cErrQ;
    logic             dErrQ;
    logic             dBad;

    assign cfgNew = cfgIn[g*CFG_W +: CFG_W];
    assign dIn    = dataIn[g*TRIT_W +: TRIT_W];
    assign dBad   = (dIn == TRIT_BAD);
    assign dEff   = dBad ? heldQ : dIn;

    // merge: keep the old setting wherever the new trit is illegal
    always_comb begin
      cfgNext = cfgQ;
      cfgBad  = 1'b0;
      for (int t = 0; t < GATE_TRITS; t++) begin
        if (cfgNew[t*TRIT_W +: TRIT_W] == TRIT_BAD) begin
          cfgBad = 1'b1;
        end else begin
          cfgNext[t*TRIT_W +: TRIT_W] = cfgNew[t*TRIT_W +: TRIT_W];
        end
      end
    end

    always_comb begin
      case (dEff)
        TRIT_NEG:  gateOut = cfgQ[0*TRIT_W +: TRIT_W];
        TRIT_ZERO: gateOut = cfgQ[1*TRIT_W +: TRIT_W];
        default:   gateOut = cfgQ[2*TRIT_W +: TRIT_W];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ  <= CFG_IDENT;
        cErrQ <= 1'b0;
      end else begin
        cErrQ <= strobe.capCfg & cfgBad;
        if (strobe.capCfg) cfgQ <= cfgNext;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        heldQ <= TRIT_ZERO;
        zQ    <= TRIT_ZERO;
        dErrQ <= 1'b0;
      end else begin
        dErrQ <= strobe.capData & dBad;
        if (strobe.capData) begin
          zQ    <= gateOut;
          heldQ <= dEff;
        end
      end
    end

    assign zOut[g*TRIT_W +: TRIT_W] = strobe.outEn ? zQ : TRIT_BAD;
    assign rgbOut[g*3 +: 3]         = strobe.outEn ? tritToRgb(zQ) : 3'b000;
    assign cfgErr[g]                = cErrQ;
    assign dataErr[g]               = dErrQ;
  end
endmodule

// File: rtl/ternUnaryGateUnit.sv
module ternUnaryGateUnit
  import ternPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       cfgLoad,
  input  logic [5:0] cfgWordA,
  input  logic [5:0] cfgWordB,
  input  logic [5:0] cfgSwitch,
  input  logic [1:0] dataA,
  input  logic [1:0] dataB,
  input  logic [1:0] dataC,
  output logic [1:0] zA,
  output logic [1:0] zB,
  output logic [1:0] zC,
  output logic [2:0] rgbA,
  output logic [2:0] rgbB,
  output logic [2:0] rgbC,
  output logic       outValid,
  output logic [2:0] cfgErr,
  output logic [2:0] dataErr
);
  localparam int LANES = 3;

  ctrlStrobe_t              strobe;
  logic [LANES*TRIT_W-1:0]  zAll;
  logic [LANES*3-1:0]       rgbAll;

  ternCtrl uCtrl (
    .ceN    (ceN),
    .oeN    (oeN),
    .cfgLoad(cfgLoad),
    .strobe (strobe)
  );

  ternLaneArray #(.LANES(LANES)) uLanes (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgIn  ({cfgSwitch, cfgWordB, cfgWordA}),
    .dataIn ({dataC, dataB, dataA}),
    .zOut   (zAll),
    .rgbOut (rgbAll),
    .cfgErr (cfgErr),
    .dataErr(dataErr)
  );

  assign {zC, zB, zA}       = zAll;
  assign {rgbC, rgbB, rgbA} = rgbAll;
  assign outValid           = strobe.outEn;
endmodule

// File: rtl/ternUnaryGateUnitChk.sv
bind ternUnaryGateUnit ternUnaryGateUnitChk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .cfgLoad(cfgLoad),
  .dataA(dataA), .zA(zA), .zB(zB), .zC(zC),
  .rgbA(rgbA), .rgbB(rgbB), .rgbC(rgbC),
  .outValid(outValid), .cfgErr(cfgErr), .dataErr(dataErr)
);

module ternUnaryGateUnitChk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       oeN,
  input logic       cfgLoad,
  input logic [1:0] dataA,
  input logic [1:0] zA,
  input logic [1:0] zB,
  input logic [1:0] zC,
  input logic [2:0] rgbA,
  input logic [2:0] rgbB,
  input logic [2:0] rgbC,
  input logic       outValid,
  input logic [2:0] cfgErr,
  input logic [2:0] dataErr
);
  p_legal_out_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (zA != 2'b11) && (zB != 2'b11) && (zC != 2'b11));

  p_onehot_rgb_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(rgbA) == 1) && ($countones(rgbB) == 1) && ($countones(rgbC) == 1));

  p_rgb_red_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zA == 2'b00) |-> rgbA == 3'b100);

  p_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> (zA == 2'b11) && (zB == 2'b11) && (zC == 2'b11) && !outValid
                     && (rgbA == 3'b000) && (rgbB == 3'b000) && (rgbC == 3'b000));

  p_freeze_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (cfgErr == 3'b000) && (dataErr == 3'b000));

  p_cfg_err_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr != 3'b000) |-> $past(cfgLoad) && !$past(ceN));

  p_data_err_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataErr[0] |-> ($past(dataA) == 2'b11) && !$past(ceN));
endmodule

// File: tb/tb_ternUnaryGateUnit.sv
module tb_ternUnaryGateUnit;
  logic       clk = 1'b0;
  logic       rstN, ceN, oeN, cfgLoad;
  logic [5:0] cfgWordA, cfgWordB, cfgSwitch;
  logic [1:0] dataA, dataB, dataC;
  logic [1:0] zA, zB, zC;
  logic [2:0] rgbA, rgbB, rgbC;
  logic       outValid;
  logic [2:0] cfgErr, dataErr;

  always #4 clk = ~clk;

  ternUnaryGateUnit dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .cfgLoad(cfgLoad),
    .cfgWordA(cfgWordA), .cfgWordB(cfgWordB), .cfgSwitch(cfgSwitch),
    .dataA(dataA), .dataB(dataB), .dataC(dataC),
    .zA(zA), .zB(zB), .zC(zC), .rgbA(rgbA), .rgbB(rgbB), .rgbC(rgbC),
    .outValid(outValid), .cfgErr(cfgErr), .dataErr(dataErr)
  );

  typedef struct {
    logic [5:0] z;
    logic [8:0] rgb;
    logic       v;
    logic [2:0] ce;
    logic [2:0] de;
    string      req;
  } expItem_t;

  expItem_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model, values -1/0/+1, 2 = illegal
  int cfgM[3][3];
  int heldM[3];
  int zM[3];
  bit cErrM[3];
  bit dErrM[3];

  function automatic int dec(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b10: return 0;
      2'b01: return -1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [1:0] enc(input int v);
    if (v == 1) return 2'b00;
    if (v == 0) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [2:0] rgbOf(input int v);
    if (v == 1) return 3'b100;
    if (v == 0) return 3'b010;
    return 3'b001;
  endfunction

  function automatic expItem_t expected(input bit en, input string req);
    expItem_t e;
    for (int l = 0; l < 3; l++) begin
      e.z[l*2 +: 2]   = en ? enc(zM[l]) : 2'b11;
      e.rgb[l*3 +: 3] = en ? rgbOf(zM[l]) : 3'b000;
      e.ce[l] = cErrM[l];
      e.de[l] = dErrM[l];
    end
    e.v   = en;
    e.req = req;
    return e;
  endfunction

  task automatic compare(input expItem_t e);
    logic [5:0] zAct;
    logic [8:0] rAct;
    zAct = {zC, zB, zA};
    rAct = {rgbC, rgbB, rgbA};
    nChecks++;
    if (zAct !== e.z || rAct !== e.rgb || outValid !== e.v ||
        cfgErr !== e.ce || dataErr !== e.de) begin
      nFails++;
      $display("FAIL %s: actual z=%b rgb=%b v=%b cErr=%b dErr=%b expected z=%b rgb=%b v=%b cErr=%b dErr=%b",
               e.req, zAct, rAct, outValid, cfgErr, dataErr, e.z, e.rgb, e.v, e.ce, e.de);
    end
  endtask

  // driver: apply one cycle of stimulus, update model at the edge, push expectation
  task automatic step(input logic [1:0] a, b, c, input logic [5:0] wa, wb, ws,
                      input logic ld, ce, oe, input string req);
    logic [1:0] dIn[3];
    logic [5:0] wIn[3];
    int zNew[3];
    @(negedge clk);
    dataA = a; dataB = b; dataC = c;
    cfgWordA = wa; cfgWordB = wb; cfgSwitch = ws;
    cfgLoad = ld; ceN = ce; oeN = oe;
    dIn[0] = a; dIn[1] = b; dIn[2] = c;
    wIn[0] = wa; wIn[1] = wb; wIn[2] = ws;
    @(posedge clk);
    for (int l = 0; l < 3; l++) begin
      if (!ce) begin
        int d;
        int eff;
        d = dec(dIn[l]);
        eff = (d == 2) ? heldM[l] : d;
        zNew[l] = cfgM[l][eff + 1];
        dErrM[l] = (d == 2);
        heldM[l] = eff;
        cErrM[l] = 1'b0;
        if (ld) begin
          for (int t = 0; t < 3; t++) begin
            int v;
            v = dec(wIn[l][t*2 +: 2]);
            if (v == 2) cErrM[l] = 1'b1;
            else cfgM[l][t] = v;
          end
        end
        zM[l] = zNew[l];
      end else begin
        dErrM[l] = 1'b0;
        cErrM[l] = 1'b0;
      end
    end
    q.push_back(expected(!ce && !oe, req));
  endtask

  // monitor: compare one cycle after each edge, before the next drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  localparam logic [5:0] W_IDENT = 6'b00_10_01;
  localparam logic [5:0] W_INV   = 6'b01_10_00;
  localparam logic [5:0] W_CPOS  = 6'b00_00_00;
  localparam logic [5:0] W_ROT   = 6'b01_00_10;
  localparam logic [5:0] W_CNEG  = 6'b01_01_01;

  initial begin
    logic [1:0] codes[3];
    codes[0] = 2'b01; codes[1] = 2'b10; codes[2] = 2'b00;
    for (int l = 0; l < 3; l++) begin
      cfgM[l][0] = -1; cfgM[l][1] = 0; cfgM[l][2] = 1;
      heldM[l] = 0; zM[l] = 0; cErrM[l] = 0; dErrM[l] = 0;
    end
    rstN = 1'b0; ceN = 1'b0; oeN = 1'b0; cfgLoad = 1'b0;
    cfgWordA = W_IDENT; cfgWordB = W_IDENT; cfgSwitch = W_IDENT;
    dataA = 2'b10; dataB = 2'b10; dataC = 2'b10;
    repeat (3) @(negedge clk);
    compare(expected(1'b1, "R10 reset state"));
    rstN = 1'b1;

    // R10: identity gates after reset
    step(2'b00, 2'b10, 2'b01, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R10 identity");
    // R3: load edge still maps with old configuration
    step(2'b00, 2'b00, 2'b00, W_INV, W_CPOS, W_ROT, 1'b1, 1'b0, 1'b0, "R3 load edge");
    // R1 R2 R4 R7: sweep every data combination through three distinct gates
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 3; k++)
          step(codes[i], codes[j], codes[k], W_INV, W_CPOS, W_ROT, 1'b0, 1'b0, 1'b0,
               "R1 R2 R4 R7 mapping");
    // R3: new words without strobe are ignored
    step(2'b01, 2'b01, 2'b01, W_CNEG, W_CNEG, W_CNEG, 1'b0, 1'b0, 1'b0, "R3 no strobe");
    step(2'b00, 2'b10, 2'b00, W_CNEG, W_CNEG, W_CNEG, 1'b0, 1'b0, 1'b0, "R3 no strobe");
    // R9 R8: load and data while disabled are ignored, outputs masked
    step(2'b00, 2'b00, 2'b00, W_CNEG, W_CNEG, W_CNEG, 1'b1, 1'b1, 1'b0, "R9 R8 disabled load");
    step(2'b11, 2'b01, 2'b11, W_CNEG, W_CNEG, W_CNEG, 1'b1, 1'b1, 1'b0, "R9 R8 disabled data");
    step(2'b01, 2'b01, 2'b01, W_CNEG, W_CNEG, W_CNEG, 1'b0, 1'b0, 1'b0, "R9 re-enable");
    // R5: illegal middle trit keeps old 0-slot, other slots load
    step(2'b10, 2'b10, 2'b10, 6'b00_11_10, W_IDENT, 6'b11_11_11, 1'b1, 1'b0, 1'b0, "R5 partial load");
    step(2'b01, 2'b01, 2'b01, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R5 flag clears");
    step(2'b10, 2'b00, 2'b00, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R5 merged gate");
    step(2'b00, 2'b10, 2'b10, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R5 merged gate");
    // R6: illegal data holds last legal trit
    step(2'b11, 2'b01, 2'b11, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R6 illegal data");
    step(2'b11, 2'b11, 2'b01, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R6 repeated illegal");
    step(2'b01, 2'b00, 2'b10, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R6 recover");
    // R8: output enable high masks but state keeps moving
    step(2'b10, 2'b10, 2'b00, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b1, "R8 oe masked");
    step(2'b00, 2'b01, 2'b01, W_IDENT, W_IDENT, W_IDENT, 1'b0, 1'b0, 1'b0, "R8 oe restored");

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule